// File: doc/BRIEF.md
# SD Host Command Path Engine

This block runs the command half of an SD host. Software writes a 32-bit argument and a 32-bit command word. The engine builds a 48-bit command token and protects it with a CRC7. It shifts the token out on the single-bit CMD line, most significant bit first, one bit per SD clock tick. Then, if the command word asks for one, it listens for the card's response and checks it. The response is stored in a 128-bit response bank, and the outcome is reported through sticky status flags. A command-inhibit output stays high for the whole life of a command.

The command word has these fields:
- bits 29:24 hold the command index;
- bit 20 enables the response index check;
- bit 19 enables the response CRC check;
- bits 17:16 hold the response kind.

The other bits of the word are ignored. Sequencing advances only on cycles where `sd_tick` is high, so one engine serves any SD bus rate. An init-stream control input turns an issued command into a run of idle clocks with the line driven high, which wakes a freshly powered card.

The FSM states are:
- **IDLE**: waits for a write.
- **SEND**: shifts the token out.
- **WAIT**: looks for the response start bit.
- **RECV**: shifts the response in.
- **CHECK**: one cycle of evaluation.
- **BUSY**: waits for the card to release the busy line.
- **INIT**: drives the init clock stream.

The transitions are:
- IDLE→SEND on a write, or IDLE→INIT on a write with init-stream set.
- SEND→IDLE after the end bit for kind 00, or SEND→WAIT after the end bit for other kinds.
- WAIT→RECV when a low start bit is seen, or WAIT→IDLE on timeout.
- RECV→CHECK when the last bit is in.
- CHECK→BUSY for kind 11, or CHECK→IDLE otherwise.
- BUSY→IDLE when the busy line reads high.
- INIT→IDLE when the stream count is used up.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command drives CMD for exactly 48 ticks, most significant bit first. The token is {0, 1, index[5:0], argument[31:0], CRC7, 1}. The CRC7 uses x^7+x^3+1 over the first 40 bits. An argument written in the same cycle as the command is the one sent.
- R2: Response kind 00 in bits 17:16 means no response. The command completes right after the end bit and sets status bit 0 (complete).
- R3: For the other kinds, the engine samples CMD on ticks after the end bit. A low start bit must appear within 64 ticks. If it does not, status bit 16 (timeout) is set without bit 0. Kind 10 and kind 11 take 48 response bits. Kind 01 takes 136 response bits.
- R4: After a 48-bit response, response word 0 holds response bits 39:8, and words 1 to 3 keep their previous values.
- R5: After a 136-bit response, the 128-bit bank holds {8'h00, response bits 127:8}. Word 0 is the least significant.
- R6: A CRC7 mismatch sets status bit 17, but only when command bit 19 is set. The CRC is taken over response bits 47:8 for a 48-bit response and bits 127:8 for a 136-bit response, and compared with bits 7:1.
- R7: A response whose end bit (bit 0) is 0 sets status bit 18.
- R8: For a 48-bit response with command bit 20 set, the engine compares response bits 45:40 with the command index. A mismatch sets status bit 19. No index check is made on 136-bit responses.
- R9: For kind 11, complete (bit 0) is withheld after the response until a tick samples `card_busy_n` high.
- R10: `cmd_inhibit` is high from the cycle after acceptance until the command ends. While it is high, command writes are ignored. Acceptance clears all status bits, and the status bits are otherwise held while idle.
- R11: With `init_stream` high, an issued command drives CMD high for 80 ticks and then sets bit 0, with no response phase.
- R12: With `sd_tick` low, the line and the sequencing hold still.
- R13: Reset leaves the engine idle, with CMD undriven and all status and response bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_tick | input | 1 | One-cycle SD clock enable |
| cmd_wr | input | 1 | Command word write strobe; starts a command when idle |
| cmd_word | input | 32 | Command word (index, check enables, response kind) |
| arg_wr | input | 1 | Argument write strobe |
| arg_in | input | 32 | Command argument |
| init_stream | input | 1 | Issue init clock stream instead of a token |
| cmd_in | input | 1 | CMD line as seen from the card |
| card_busy_n | input | 1 | Card busy line, low while busy |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_inhibit | output | 1 | Command in flight |
| status | output | 32 | Sticky flags: 0 complete, 16 timeout, 17 CRC, 18 end bit, 19 index |
| resp_regs | output | 128 | Response bank, word k at bits 32k+31:32k |

## Verification
The bench aims at these corner cases:
- **Start bit on the last allowed tick versus one tick later.** An off-by-one timeout counter would pass one case and flag the other wrongly.
- **CRC and index errors with their check enable off as well as on.** An engine that ignores the enables raises flags nobody asked for.
- **A 48-bit response after a 136-bit one.** This shows the upper response words are not clobbered.
- **A busy stretch.** Complete arriving at the response end instead of at the busy release shows up as a cycle mismatch on `cmd_inhibit`.
- **A second command write in mid-flight.** A restarted or altered token would differ from the predicted line bit by bit.
- **A sparse tick.** A design that advanced on every system clock would emit too few sampled bits.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_CHECK,
        ST_BUSY,
        ST_INIT
    } cmd_state_t;

    typedef enum logic [1:0] {
        RSP_NONE       = 2'b00,
        RSP_LONG       = 2'b01,
        RSP_SHORT      = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_t;

    // status bit positions
    localparam int STAT_CC   = 0;
    localparam int STAT_CTO  = 16;
    localparam int STAT_CCRC = 17;
    localparam int STAT_CEB  = 18;
    localparam int STAT_CIE  = 19;

    // command word field positions
    localparam int FLD_IDX_LO = 24;
    localparam int FLD_IDX_EN = 20;
    localparam int FLD_CRC_EN = 19;
    localparam int FLD_RSP_LO = 16;

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7 #(
    parameter int NBITS = 40
) (
    input  logic [NBITS-1:0] bits_in,
    output logic [6:0]       crc_out
);

    // serial CRC7 (x^7 + x^3 + 1), first bit = MSB of bits_in
    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            fb  = bits_in[i] ^ acc[6];
            acc = {acc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/sd_cmd_resp_check.sv
module sd_cmd_resp_check #(
    parameter int IDX_W   = 6,
    parameter int WORD_W  = 32,
    parameter int WORDS_W = 128
) (
    input  logic [WORDS_W+7:0]  frame,
    input  logic                is_long,
    input  logic [IDX_W-1:0]    exp_idx,
    output logic                crc_bad,
    output logic                end_bad,
    output logic                idx_bad,
    output logic [WORD_W-1:0]   short_word,
    output logic [WORDS_W-1:0]  long_words
);

    localparam int SHORT_W   = 2 + IDX_W + WORD_W + 8;
    localparam int SHORT_PAY = SHORT_W - 8;
    localparam int LONG_W    = WORDS_W + 8;
    localparam int LONG_PAY  = LONG_W - 16;

    logic [6:0] crc_short;
    logic [6:0] crc_long;

    sd_cmd_crc7 #(.NBITS(SHORT_PAY)) u_crc_short (
        .bits_in (frame[SHORT_W-1:8]),
        .crc_out (crc_short)
    );

    sd_cmd_crc7 #(.NBITS(LONG_PAY)) u_crc_long (
        .bits_in (frame[LONG_W-9:8]),
        .crc_out (crc_long)
    );

    always_comb begin
        end_bad    = ~frame[0];
        crc_bad    = is_long ? (crc_long != frame[7:1]) : (crc_short != frame[7:1]);
        idx_bad    = ~is_long && (frame[SHORT_W-3 -: IDX_W] != exp_idx);
        short_word = frame[SHORT_W-9 -: WORD_W];
        long_words = {{(WORDS_W-LONG_PAY){1'b0}}, frame[LONG_W-9:8]};
    end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int IDX_W         = 6,
    parameter int WORD_W        = 32,
    parameter int RESP_WORDS    = 4,
    parameter int TIMEOUT_TICKS = 64,
    parameter int INIT_TICKS    = 80
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sd_tick,
    input  logic                         cmd_wr,
    input  logic [31:0]                  cmd_word,
    input  logic                         arg_wr,
    input  logic [WORD_W-1:0]            arg_in,
    input  logic                         init_stream,
    input  logic                         cmd_in,
    input  logic                         card_busy_n,
    output logic                         cmd_out,
    output logic                         cmd_oe,
    output logic                         cmd_inhibit,
    output logic [31:0]                  status,
    output logic [RESP_WORDS*WORD_W-1:0] resp_regs
);

    localparam int WORDS_W = RESP_WORDS * WORD_W;
    localparam int TOKEN_W = 2 + IDX_W + WORD_W + 8;
    localparam int LONG_W  = WORDS_W + 8;
    localparam int CNT_MAX = (LONG_W > INIT_TICKS)
                           ? ((LONG_W > TIMEOUT_TICKS) ? LONG_W : TIMEOUT_TICKS)
                           : ((INIT_TICKS > TIMEOUT_TICKS) ? INIT_TICKS : TIMEOUT_TICKS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(TOKEN_W - 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_TICKS - 1);
    localparam logic [CNT_W-1:0] TO_LAST    = CNT_W'(TIMEOUT_TICKS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(TOKEN_W - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_W - 1);

    cmd_state_t           state, state_nx;
    rsp_kind_t            rsp_q;
    logic [TOKEN_W-1:0]   tx_sh;
    logic [LONG_W-1:0]    rx_sh;
    logic [CNT_W-1:0]     cnt;
    logic [WORD_W-1:0]    arg_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 crc_en_q, idx_en_q;
    logic [31:0]          stat_q;
    logic [WORDS_W-1:0]   resp_q;

    // token assembly
    logic [IDX_W-1:0]     new_idx;
    logic [WORD_W-1:0]    new_arg;
    logic [TOKEN_W-9:0]   tok_body;
    logic [6:0]           tok_crc;
    logic [TOKEN_W-1:0]   token;

    assign new_idx  = cmd_word[FLD_IDX_LO +: IDX_W];
    assign new_arg  = arg_wr ? arg_in : arg_q;
    assign tok_body = {2'b01, new_idx, new_arg};
    assign token    = {tok_body, tok_crc, 1'b1};

    sd_cmd_crc7 #(.NBITS(TOKEN_W - 8)) u_tx_crc (
        .bits_in (tok_body),
        .crc_out (tok_crc)
    );

    // response evaluation
    logic                 crc_bad, end_bad, idx_bad;
    logic [WORD_W-1:0]    short_word;
    logic [WORDS_W-1:0]   long_words;
    logic                 is_long;
    logic [CNT_W-1:0]     rx_last;

    assign is_long = (rsp_q == RSP_LONG);
    assign rx_last = is_long ? LONG_LAST : SHORT_LAST;

    sd_cmd_resp_check #(.IDX_W(IDX_W), .WORD_W(WORD_W), .WORDS_W(WORDS_W)) u_check (
        .frame      (rx_sh),
        .is_long    (is_long),
        .exp_idx    (idx_q),
        .crc_bad    (crc_bad),
        .end_bad    (end_bad),
        .idx_bad    (idx_bad),
        .short_word (short_word),
        .long_words (long_words)
    );

    // command word bits with no meaning for this engine
    logic unused_fields;
    assign unused_fields = ^{cmd_word[31:30], cmd_word[23:21], cmd_word[18], cmd_word[15:0]};

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cmd_wr) state_nx = init_stream ? ST_INIT : ST_SEND;
            ST_SEND:  if (sd_tick && cnt == '0)
                          state_nx = (rsp_q == RSP_NONE) ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (sd_tick) begin
                          if (!cmd_in)             state_nx = ST_RECV;
                          else if (cnt == TO_LAST) state_nx = ST_IDLE;
                      end
            ST_RECV:  if (sd_tick && cnt == rx_last) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (rsp_q == RSP_SHORT_BUSY) ? ST_BUSY : ST_IDLE;
            ST_BUSY:  if (sd_tick && card_busy_n) state_nx = ST_IDLE;
            ST_INIT:  if (sd_tick && cnt == '0) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rsp_q    <= RSP_NONE;
            tx_sh    <= '0;
            rx_sh    <= '0;
            cnt      <= '0;
            arg_q    <= '0;
            idx_q    <= '0;
            crc_en_q <= 1'b0;
            idx_en_q <= 1'b0;
            stat_q   <= '0;
            resp_q   <= '0;
        end else begin
            state <= state_nx;
            if (arg_wr) arg_q <= arg_in;
            unique case (state)
                ST_IDLE: if (cmd_wr) begin
                    stat_q   <= '0;
                    idx_q    <= new_idx;
                    rsp_q    <= rsp_kind_t'(cmd_word[FLD_RSP_LO +: 2]);
                    crc_en_q <= cmd_word[FLD_CRC_EN];
                    idx_en_q <= cmd_word[FLD_IDX_EN];
                    tx_sh    <= token;
                    cnt      <= init_stream ? INIT_LAST : TX_LAST;
                end
                ST_SEND: if (sd_tick) begin
                    if (cnt == '0) begin
                        if (rsp_q == RSP_NONE) stat_q[STAT_CC] <= 1'b1;
                    end else begin
                        cnt   <= cnt - 1'b1;
                        tx_sh <= {tx_sh[TOKEN_W-2:0], 1'b0};
                    end
                end
                ST_WAIT: if (sd_tick) begin
                    rx_sh <= {rx_sh[LONG_W-2:0], cmd_in};
                    if (!cmd_in)             cnt <= CNT_W'(1);
                    else if (cnt == TO_LAST) stat_q[STAT_CTO] <= 1'b1;
                    else                     cnt <= cnt + 1'b1;
                end
                ST_RECV: if (sd_tick) begin
                    rx_sh <= {rx_sh[LONG_W-2:0], cmd_in};
                    cnt   <= cnt + 1'b1;
                end
                ST_CHECK: begin
                    stat_q[STAT_CCRC] <= crc_en_q & crc_bad;
                    stat_q[STAT_CEB]  <= end_bad;
                    stat_q[STAT_CIE]  <= idx_en_q & idx_bad;
                    if (rsp_q != RSP_SHORT_BUSY) stat_q[STAT_CC] <= 1'b1;
                    if (is_long) resp_q <= long_words;
                    else         resp_q[WORD_W-1:0] <= short_word;
                end
                ST_BUSY: if (sd_tick && card_busy_n) stat_q[STAT_CC] <= 1'b1;
                ST_INIT: if (sd_tick) begin
                    if (cnt == '0) stat_q[STAT_CC] <= 1'b1;
                    else           cnt <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_oe      = (state == ST_SEND) || (state == ST_INIT);
        cmd_out     = (state == ST_SEND) ? tx_sh[TOKEN_W-1] : 1'b1;
        cmd_inhibit = (state != ST_IDLE);
        status      = stat_q;
        resp_regs   = resp_q;
    end

endmodule

// File: rtl/sd_cmd_engine_checker.sv
module sd_cmd_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sd_tick,
    input logic        cmd_wr,
    input logic        cmd_oe,
    input logic        cmd_out,
    input logic        cmd_inhibit,
    input logic [31:0] status
);

    // R10: the line is only driven while a command is in flight
    a_r10_drive_needs_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> cmd_inhibit);

    // R10: acceptance clears every flag
    a_r10_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_inhibit) |-> (status == 32'h0));

    // R10: flags hold while idle and nothing is written
    a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_inhibit && !cmd_wr) |=> $stable(status));

    // R3: a timeout never comes with complete
    a_r3_cc_cto_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[0] && status[16]));

    // R7: a finished response with an error flag also reports complete
    a_r7_error_with_cc: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[17] || status[18] || status[19]) && !cmd_inhibit) |-> status[0]);

    // R12: no tick, no change on the driven line
    a_r12_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oe && !sd_tick) |=> $stable(cmd_out));

endmodule

bind sd_cmd_engine sd_cmd_engine_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_tick     (sd_tick),
    .cmd_wr      (cmd_wr),
    .cmd_oe      (cmd_oe),
    .cmd_out     (cmd_out),
    .cmd_inhibit (cmd_inhibit),
    .status      (status)
);

// File: tb/sd_cmd_engine_test.sv
`timescale 1ns/100ps
module sd_cmd_engine_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sd_tick = 1'b1;
    logic         cmd_wr = 1'b0;
    logic [31:0]  cmd_word = '0;
    logic         arg_wr = 1'b0;
    logic [31:0]  arg_in = '0;
    logic         init_stream = 1'b0;
    logic         cmd_in = 1'b1;
    logic         card_busy_n = 1'b1;
    logic         cmd_out, cmd_oe, cmd_inhibit;
    logic [31:0]  status;
    logic [127:0] resp_regs;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sd_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .cmd_wr(cmd_wr),
        .cmd_word(cmd_word), .arg_wr(arg_wr), .arg_in(arg_in),
        .init_stream(init_stream), .cmd_in(cmd_in), .card_busy_n(card_busy_n),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_inhibit(cmd_inhibit),
        .status(status), .resp_regs(resp_regs)
    );

    task automatic chk(input string req, input logic [135:0] act, input logic [135:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_ref(input logic [135:0] v, input int n);
        logic [6:0] c = 7'h0;
        for (int i = n - 1; i >= 0; i--) begin
            logic b = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (b) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] token_ref(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] body = {2'b01, idx, arg};
        return {body, crc_ref({96'h0, body}, 40), 1'b1};
    endfunction

    function automatic logic [31:0] mk_word(input int idx, input bit ien, input bit cen, input int kind);
        return (32'(idx) << 24) | (32'(ien) << 20) | (32'(cen) << 19) | (32'(kind) << 16);
    endfunction

    function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] pay,
                                                 input bit flip_crc, input bit bad_end);
        logic [39:0] body = {2'b00, idx, pay};
        logic [6:0]  c = crc_ref({96'h0, body}, 40) ^ (flip_crc ? 7'h01 : 7'h00);
        return {88'h0, body, c, ~bad_end};
    endfunction

    function automatic logic [135:0] long_frame(input logic [119:0] content);
        return {2'b00, 6'h3F, content, crc_ref({16'h0, content}, 120), 1'b1};
    endfunction

    // Issue one command and compare line, inhibit and status on every cycle.
    task automatic run_cmd(input logic [31:0] word, input logic [31:0] arg, input int delay,
                           input logic [135:0] frame, input int flen, input int busy_len,
                           input bit inject, input string req);
        logic [47:0] tok = token_ref(word[29:24], arg);
        int kind = int'(word[17:16]);
        int s = 49 + delay;
        int e;
        if (kind == 0)          e = 48;
        else if (delay >= 64)   e = 112;
        else if (kind == 3)     e = s + flen + 1 + busy_len;
        else                    e = s + flen;
        for (int i = 0; i <= e + 1; i++) begin
            @(negedge clk);
            if (i > 0) begin
                int j = i - 1;
                chk({req, " R1 drive enable"}, 136'(cmd_oe), 136'(j <= 47));
                if (j <= 47) chk({req, " R1 token bit"}, 136'(cmd_out), 136'(tok[47 - j]));
                chk({req, " R10 inhibit"}, 136'(cmd_inhibit), 136'(j < e));
                if (j < e) chk({req, " R10 status cleared"}, 136'(status), 136'h0);
            end
            cmd_wr      = (i == 0) || (inject && i == 5);
            cmd_word    = (i == 0) ? word : 32'h3F3B_0000;
            arg_wr      = (i == 0) || (inject && i == 5);
            arg_in      = (i == 0) ? arg : 32'hDEAD_BEEF;
            if (i >= s && i < s + flen) cmd_in = frame[flen - 1 - (i - s)];
            else                        cmd_in = 1'b1;
            card_busy_n = !(kind == 3 && i >= s + flen + 1 && i < s + flen + 1 + busy_len);
        end
        @(negedge clk);
        cmd_wr = 1'b0; arg_wr = 1'b0; cmd_in = 1'b1; card_busy_n = 1'b1;
    endtask

    logic [119:0] lc;
    logic [127:0] bank;

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset oe", 136'(cmd_oe), 136'h0);
        chk("R13 reset inhibit", 136'(cmd_inhibit), 136'h0);
        chk("R13 reset status", 136'(status), 136'h0);
        chk("R13 reset resp", 136'(resp_regs), 136'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no-response commands, two tokens
        run_cmd(mk_word(0, 0, 0, 0), 32'h0, 0, '0, 0, 0, 0, "R2 idx0");
        chk("R2 complete", 136'(status), 136'h1);
        run_cmd(mk_word(17, 1, 1, 0), 32'hA5A5_1234, 0, '0, 0, 0, 0, "R1 idx17");
        chk("R1 complete", 136'(status), 136'h1);

        // R5: long response
        lc = {32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 24'hDDEEFF};
        run_cmd(mk_word(2, 1, 1, 1), 32'h0000_0001, 3, long_frame(lc), 136, 0, 0, "R5 long");
        chk("R5 status", 136'(status), 136'h1);
        chk("R5 bank", 136'(resp_regs), 136'({8'h0, lc}));
        bank = {8'h0, lc};

        // R4: short response keeps upper words
        run_cmd(mk_word(13, 1, 1, 2), 32'h0000_1000, 2, short_frame(13, 32'hCAFE_0001, 0, 0), 48, 0, 0, "R4 short");
        chk("R4 status", 136'(status), 136'h1);
        chk("R4 word0 and upper words kept", 136'(resp_regs), 136'({bank[127:32], 32'hCAFE_0001}));

        // R6: CRC error with and without enable (mid-flight write injected, R10)
        run_cmd(mk_word(13, 0, 1, 2), 32'h7, 1, short_frame(13, 32'h1234_5678, 1, 0), 48, 0, 1, "R6 crc on");
        chk("R6 crc flag enabled", 136'(status), 136'h2_0001);
        run_cmd(mk_word(13, 0, 0, 2), 32'h7, 1, short_frame(13, 32'h1234_5678, 1, 0), 48, 0, 0, "R6 crc off");
        chk("R6 crc flag disabled", 136'(status), 136'h1);

        // R8: index mismatch with and without enable
        run_cmd(mk_word(13, 1, 1, 2), 32'h9, 0, short_frame(14, 32'h0000_0AAA, 0, 0), 48, 0, 0, "R8 idx on");
        chk("R8 index flag enabled", 136'(status), 136'h8_0001);
        run_cmd(mk_word(13, 0, 1, 2), 32'h9, 0, short_frame(14, 32'h0000_0AAA, 0, 0), 48, 0, 0, "R8 idx off");
        chk("R8 index flag disabled", 136'(status), 136'h1);

        // R7: bad end bit
        run_cmd(mk_word(5, 0, 0, 2), 32'h5, 4, short_frame(5, 32'h0BAD_0E0D, 0, 1), 48, 0, 0, "R7 end");
        chk("R7 end bit flag", 136'(status), 136'h4_0001);
        repeat (3) @(negedge clk);
        chk("R10 status held idle", 136'(status), 136'h4_0001);

        // R3: start bit on last allowed tick, then one tick late
        run_cmd(mk_word(8, 1, 1, 2), 32'h1AA, 63, short_frame(8, 32'h0000_01AA, 0, 0), 48, 0, 0, "R3 edge");
        chk("R3 last allowed tick", 136'(status), 136'h1);
        run_cmd(mk_word(8, 1, 1, 2), 32'h1AA, 64, short_frame(8, 32'h0000_01AA, 0, 0), 48, 0, 0, "R3 late");
        chk("R3 timeout", 136'(status), 136'h1_0000);

        // R9: busy stretch
        run_cmd(mk_word(7, 1, 1, 3), 32'h3, 2, short_frame(7, 32'h0000_0700, 0, 0), 48, 6, 0, "R9 busy");
        chk("R9 complete after busy", 136'(status), 136'h1);

        // R11: init stream
        init_stream = 1'b1;
        for (int i = 0; i <= 81; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R11 drive enable", 136'(cmd_oe), 136'(i - 1 <= 79));
                if (i - 1 <= 79) chk("R11 line high", 136'(cmd_out), 136'h1);
                chk("R11 inhibit", 136'(cmd_inhibit), 136'(i - 1 < 80));
            end
            cmd_wr = (i == 0);
            cmd_word = mk_word(0, 0, 0, 2);
        end
        @(negedge clk);
        init_stream = 1'b0;
        chk("R11 complete", 136'(status), 136'h1);

        // R12: sparse tick, collect the bits seen at tick edges
        begin
            logic [47:0] got = '0;
            logic [47:0] tok = token_ref(6'd41, 32'h0F0F_00FF);
            int nbits = 0;
            int busy_cyc = 0;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (i > 0 && !cmd_inhibit) break;
                if (i > 0) busy_cyc++;
                cmd_wr   = (i == 0);
                arg_wr   = (i == 0);
                arg_in   = 32'h0F0F_00FF;
                cmd_word = mk_word(41, 0, 0, 0);
                sd_tick  = (i > 0) && (i % 3 == 2);
                if (sd_tick && cmd_oe && nbits < 48) begin
                    got[47 - nbits] = cmd_out;
                    nbits++;
                end
            end
            sd_tick = 1'b1; cmd_wr = 1'b0; arg_wr = 1'b0;
            chk("R12 bits sampled", 136'(nbits), 136'd48);
            chk("R12 token", 136'(got), 136'(tok));
            chk("R12 stretched", 136'(busy_cyc > 140), 136'h1);
            chk("R12 complete", 136'(status), 136'h1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule